// File: doc/BRIEF.md
# Frame-Synchronous Rectangle Fill Engine

This block paints a rectangle of a 640x480 frame buffer with one constant pixel value. It does the work in step with display refresh rather than at once. Software loads four edge coordinates and then writes a fill word that carries the pixel value and two plane enables. That write arms the engine. The fill starts at the next frame-start strobe and stays in force for exactly that frame.

During the frame, the video timing generator pulses a line-done strobe each time it finishes loading a line into its line buffer. With the strobe it gives the line number and the frame-buffer base address of that line. For every line inside the rectangle, the engine sends a burst of write requests to the memory arbiter. Each burst covers the span from the left edge to the right edge, and each write advances only when the arbiter grants it. In this way the engine follows the scan down the screen, overwriting each line just after it has been shown. A fill therefore always takes one frame, whatever its size. A line-done strobe that arrives while a burst is still running is not acted on.

Coordinates are screen coordinates with (0,0) at the upper-left pixel and (639,479) at the lower-right pixel. All four edges are inclusive.

Top module: `rect_fill_engine`

## Requirements
- R1: After reset, `busy` and `mem_req` are both low.
- R2: A write with `cpu_sel`=4 while idle arms a fill, and `busy` is high from the next cycle. No memory write occurs before the next `vt_sof` pulse, even on line-done strobes.
- R3: The first `vt_sof` after arming starts the fill. `busy` stays high until the following `vt_sof` and clears on the cycle after it, once any running burst has drained. `mem_req` is never high while `busy` is low.
- R4: On a line-done strobe during an active fill, if the line number lies in [top, bottom] inclusive, the engine issues one write per granted cycle. The addresses run from base+left up to base+right, inclusive and consecutive. Lines outside those rows produce no writes.
- R5: While `mem_req` is high and `mem_gnt` is low, the request, address, data and plane enables hold unchanged into the next cycle.
- R6: The fill word's bits [7:0] form the pixel value on `mem_data`, laid out as static bits [7:5] and dynamic bits [4:0]. Bits [9:8] appear on `mem_plane_we` (bit 8 enables plane 0, bit 9 enables plane 1). With both plane bits clear, no writes occur, but `busy` still spans the frame.
- R7: If left > right or top > bottom, no writes occur, but `busy` still spans the frame.
- R8: The edge registers (`cpu_sel` 0=top, 1=bottom, 2=left, 3=right, taking the low bits of `cpu_wdata`) are captured at the frame-start pulse that begins the fill. Later writes to them do not change the fill in progress.
- R9: A fill-word write while `busy` is high is ignored. It neither re-arms the engine nor starts a fill in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_sel | input | 3 | Register select: 0 top, 1 bottom, 2 left, 3 right, 4 fill word |
| cpu_wdata | input | 10 | Register write data |
| busy | output | 1 | Fill armed or in progress |
| vt_sof | input | 1 | Frame-start pulse from the timing generator |
| vt_line_done | input | 1 | Line-buffer load completed |
| vt_line | input | 9 | Line number of the completed load |
| vt_line_base | input | 19 | Frame-buffer address of pixel 0 of that line |
| mem_req | output | 1 | Write request to the arbiter |
| mem_gnt | input | 1 | Arbiter grant for the current request |
| mem_addr | output | 19 | Write address |
| mem_data | output | 8 | Pixel value to write |
| mem_plane_we | output | 2 | Per-plane write enables |

## Verification
The hardest case to reach from the ports is a burst that must stall under arbiter back-pressure. It is harder still when that burst spans the full line width on the very last row, where an off-by-one at either inclusive edge or a lost address under a withheld grant would show. The bench reaches this case by toggling the grant every cycle while it fills row 479 from column 0 to column 639. It checks the write count, the first and last addresses, the step between addresses and the hold of the request under a withheld grant. A second hard case is an edge rewrite in the middle of a fill. The bench changes the left edge after the frame has started and shows that the burst still begins at the captured edge.

// File: rtl/rfill_pkg.sv
package rfill_pkg;
  typedef enum logic [2:0] {
    SEL_TOP   = 3'd0,
    SEL_BOT   = 3'd1,
    SEL_LEFT  = 3'd2,
    SEL_RIGHT = 3'd3,
    SEL_WORD  = 3'd4
  } reg_sel_e;

  typedef enum logic [1:0] {
    FS_IDLE   = 2'd0,
    FS_ARMED  = 2'd1,
    FS_ACTIVE = 2'd2
  } frame_state_e;

  typedef struct packed {
    logic [1:0] planes;
    logic [7:0] pix;
  } fill_word_t;
endpackage

// File: rtl/rfill_regs.sv
module rfill_regs
  import rfill_pkg::*;
#(
  parameter int X_W  = 10,
  parameter int Y_W  = 9,
  parameter int WD_W = 10
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             cpu_wr,
  input  logic [2:0]       cpu_sel,
  input  logic [WD_W-1:0]  cpu_wdata,
  input  logic             arm_ok,
  input  logic             take,
  output logic             arm,
  output logic [Y_W-1:0]   top_q,
  output logic [Y_W-1:0]   bot_q,
  output logic [X_W-1:0]   left_q,
  output logic [X_W-1:0]   right_q,
  output fill_word_t       word_q
);
  logic [Y_W-1:0] sh_top, sh_bot;
  logic [X_W-1:0] sh_left, sh_right;
  logic           wr_top, wr_bot, wr_left, wr_right;

  always_comb begin
    wr_top   = cpu_wr && (cpu_sel == SEL_TOP);
    wr_bot   = cpu_wr && (cpu_sel == SEL_BOT);
    wr_left  = cpu_wr && (cpu_sel == SEL_LEFT);
    wr_right = cpu_wr && (cpu_sel == SEL_RIGHT);
    arm      = cpu_wr && (cpu_sel == SEL_WORD) && arm_ok;
  end

  // software-visible edge registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      sh_top   <= '0;
      sh_bot   <= '0;
      sh_left  <= '0;
      sh_right <= '0;
    end else begin
      if (wr_top)   sh_top   <= cpu_wdata[Y_W-1:0];
      if (wr_bot)   sh_bot   <= cpu_wdata[Y_W-1:0];
      if (wr_left)  sh_left  <= cpu_wdata[X_W-1:0];
      if (wr_right) sh_right <= cpu_wdata[X_W-1:0];
    end
  end

  // working copies, captured at the frame start that begins a fill
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      top_q   <= '0;
      bot_q   <= '0;
      left_q  <= '0;
      right_q <= '0;
      word_q  <= '0;
    end else begin
      if (take) begin
        top_q   <= sh_top;
        bot_q   <= sh_bot;
        left_q  <= sh_left;
        right_q <= sh_right;
      end
      if (arm) word_q <= cpu_wdata[9:0];
    end
  end

  AST_EDGES_FROZEN: assert property (@(posedge clk) disable iff (!rst_sn)
    (cpu_wr && !take) |=> $stable({top_q, bot_q, left_q, right_q})) // R8
    else $error("edge copy changed without frame start");
endmodule

// File: rtl/rfill_seq.sv
module rfill_seq
  import rfill_pkg::*;
#(
  parameter int X_W = 10,
  parameter int Y_W = 9
) (
  input  logic           clk,
  input  logic           rst_sn,
  input  logic           arm,
  input  logic           sof,
  input  logic           line_done,
  input  logic [Y_W-1:0] line,
  input  logic [Y_W-1:0] top_q,
  input  logic [Y_W-1:0] bot_q,
  input  logic [X_W-1:0] left_q,
  input  logic [X_W-1:0] right_q,
  input  logic [1:0]     planes,
  input  logic           bursting,
  output logic           take,
  output logic           start,
  output logic           in_frame
);
  frame_state_e st_q, st_n;
  logic         row_hit, span_ok;

  always_comb begin
    st_n = st_q;
    case (st_q)
      FS_IDLE:   if (arm) st_n = FS_ARMED;
      FS_ARMED:  if (sof) st_n = FS_ACTIVE;
      FS_ACTIVE: if (sof) st_n = FS_IDLE;
      default:   st_n = FS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) st_q <= FS_IDLE;
    else         st_q <= st_n;
  end

  always_comb begin
    row_hit  = (line >= top_q) && (line <= bot_q);
    span_ok  = (left_q <= right_q) && (planes != 2'b00);
    take     = sof && (st_q == FS_ARMED);
    start    = line_done && (st_q == FS_ACTIVE) && !bursting && row_hit && span_ok;
    in_frame = (st_q != FS_IDLE);
  end

  AST_ARM_WAITS_SOF: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == FS_ARMED && !sof) |=> (st_q == FS_ARMED)) // R2
    else $error("armed fill left early");
  AST_ONE_FRAME: assert property (@(posedge clk) disable iff (!rst_sn)
    (st_q == FS_ACTIVE && !sof) |=> (st_q == FS_ACTIVE)) // R3
    else $error("active fill ended before frame end");
endmodule

// File: rtl/rfill_burst.sv
module rfill_burst #(
  parameter int X_W    = 10,
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst_sn,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [X_W-1:0]    left_q,
  input  logic [X_W-1:0]    right_q,
  input  logic [7:0]        pix,
  input  logic [1:0]        planes,
  input  logic              mem_gnt,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_data,
  output logic [1:0]        mem_plane_we
);
  localparam int PAD = ADDR_W - X_W;

  logic              run_q, run_n;
  logic [ADDR_W-1:0] addr_q, addr_n, last_q, last_n;
  logic [7:0]        pix_q, pix_n;
  logic [1:0]        pl_q, pl_n;

  always_comb begin
    run_n  = run_q;
    addr_n = addr_q;
    last_n = last_q;
    pix_n  = pix_q;
    pl_n   = pl_q;
    if (start) begin
      run_n  = 1'b1;
      addr_n = base + {{PAD{1'b0}}, left_q};
      last_n = base + {{PAD{1'b0}}, right_q};
      pix_n  = pix;
      pl_n   = planes;
    end else if (run_q && mem_gnt) begin
      if (addr_q == last_q) run_n  = 1'b0;
      else                  addr_n = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      run_q  <= 1'b0;
      addr_q <= '0;
      last_q <= '0;
      pix_q  <= '0;
      pl_q   <= '0;
    end else begin
      run_q  <= run_n;
      addr_q <= addr_n;
      last_q <= last_n;
      pix_q  <= pix_n;
      pl_q   <= pl_n;
    end
  end

  always_comb begin
    mem_req      = run_q;
    mem_addr     = addr_q;
    mem_data     = pix_q;
    mem_plane_we = run_q ? pl_q : 2'b00;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)
                               && $stable(mem_plane_we))) // R5
    else $error("request dropped or changed without grant");
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_sn)
    (mem_req && mem_gnt && mem_req) |=> (!mem_req || mem_addr == $past(mem_addr) + 1'b1)) // R4
    else $error("burst address did not step by one");
  AST_PLANES_SET: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_req |-> (mem_plane_we != 2'b00)) // R6
    else $error("write issued with no plane enabled");
endmodule

// File: rtl/rect_fill_engine.sv
module rect_fill_engine
  import rfill_pkg::*;
#(
  parameter int H_PIX   = 640,
  parameter int V_LINES = 480,
  parameter int ADDR_W  = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [2:0]        cpu_sel,
  input  logic [9:0]        cpu_wdata,
  output logic              busy,
  input  logic              vt_sof,
  input  logic              vt_line_done,
  input  logic [$clog2(V_LINES)-1:0] vt_line,
  input  logic [ADDR_W-1:0] vt_line_base,
  output logic              mem_req,
  input  logic              mem_gnt,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_data,
  output logic [1:0]        mem_plane_we
);
  localparam int X_W = $clog2(H_PIX);
  localparam int Y_W = $clog2(V_LINES);

  logic           rst_s1, rst_sn;
  logic           arm, take, start, in_frame, arm_ok;
  logic [Y_W-1:0] top_q, bot_q;
  logic [X_W-1:0] left_q, right_q;
  fill_word_t     word_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  always_comb begin
    busy   = in_frame || mem_req;
    arm_ok = !busy;
  end

  rfill_regs #(.X_W(X_W), .Y_W(Y_W), .WD_W(10)) u_regs (
    .clk, .rst_sn, .cpu_wr, .cpu_sel, .cpu_wdata, .arm_ok, .take, .arm,
    .top_q, .bot_q, .left_q, .right_q, .word_q
  );

  rfill_seq #(.X_W(X_W), .Y_W(Y_W)) u_seq (
    .clk, .rst_sn, .arm, .sof(vt_sof), .line_done(vt_line_done), .line(vt_line),
    .top_q, .bot_q, .left_q, .right_q, .planes(word_q.planes),
    .bursting(mem_req), .take, .start, .in_frame
  );

  rfill_burst #(.X_W(X_W), .ADDR_W(ADDR_W)) u_burst (
    .clk, .rst_sn, .start, .base(vt_line_base), .left_q, .right_q,
    .pix(word_q.pix), .planes(word_q.planes), .mem_gnt,
    .mem_req, .mem_addr, .mem_data, .mem_plane_we
  );

  AST_REQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_sn)
    mem_req |-> busy) // R3
    else $error("write request outside a fill");
endmodule

// File: tb/rect_fill_engine_test.sv
module rect_fill_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [2:0]  cpu_sel = '0;
  logic [9:0]  cpu_wdata = '0;
  logic        busy;
  logic        vt_sof = 1'b0;
  logic        vt_line_done = 1'b0;
  logic [8:0]  vt_line = '0;
  logic [18:0] vt_line_base = '0;
  logic        mem_req;
  logic        mem_gnt = 1'b1;
  logic [18:0] mem_addr;
  logic [7:0]  mem_data;
  logic [1:0]  mem_plane_we;

  int checks = 0, fails = 0, cycles = 0;
  bit gnt_gap = 1'b0;
  bit done = 1'b0;

  // write monitor
  int          n_wr, seq_err, hold_err;
  logic [18:0] first_a, last_a, wait_addr;
  logic [7:0]  seen_data;
  logic [1:0]  seen_we;
  bit          waiting;

  rect_fill_engine uut (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    mem_gnt <= gnt_gap ? ~mem_gnt : 1'b1;
  end

  always @(negedge clk) begin
    if (waiting && (!mem_req || mem_addr != wait_addr)) hold_err++;
    waiting = mem_req && !mem_gnt;
    wait_addr = mem_addr;
    if (mem_req && mem_gnt) begin
      if (n_wr == 0) first_a = mem_addr;
      else if (mem_addr != last_a + 1) seq_err++;
      last_a = mem_addr;
      seen_data = mem_data;
      seen_we = mem_plane_we;
      n_wr++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    n_wr = 0; seq_err = 0; hold_err = 0; first_a = '0; last_a = '0;
  endtask

  task automatic cpu_write(input logic [2:0] sel, input logic [9:0] d);
    @(posedge clk); #1;
    cpu_wr = 1'b1; cpu_sel = sel; cpu_wdata = d;
    @(posedge clk); #1;
    cpu_wr = 1'b0;
  endtask

  task automatic setup(input int t, input int b, input int l, input int r, input logic [9:0] w);
    cpu_write(3'd0, 10'(t));
    cpu_write(3'd1, 10'(b));
    cpu_write(3'd2, 10'(l));
    cpu_write(3'd3, 10'(r));
    cpu_write(3'd4, w);
  endtask

  task automatic sof();
    @(posedge clk); #1; vt_sof = 1'b1;
    @(posedge clk); #1; vt_sof = 1'b0;
  endtask

  task automatic line(input int y, input int base);
    clr_mon();
    @(posedge clk); #1;
    vt_line_done = 1'b1; vt_line = 9'(y); vt_line_base = 19'(base);
    @(posedge clk); #1;
    vt_line_done = 1'b0;
    repeat (2) @(posedge clk);
    while (mem_req) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    chk("R1 busy after reset", busy, 0);
    chk("R1 mem_req after reset", mem_req, 0);
  endtask

  task automatic t_basic();
    setup(2, 3, 5, 8, 10'h1A5);
    chk("R2 busy after arm", busy, 1);
    line(2, 1280);
    chk("R2 no write before sof", n_wr, 0);
    sof();
    line(1, 640);
    chk("R4 row above top", n_wr, 0);
    line(2, 1280);
    chk("R4 count row 2", n_wr, 4);
    chk("R4 first addr", first_a, 1285);
    chk("R4 last addr", last_a, 1288);
    chk("R4 consecutive", seq_err, 0);
    chk("R6 pixel data", seen_data, 8'hA5);
    chk("R6 plane enables", seen_we, 2'b01);
    line(3, 1920);
    chk("R4 bottom row inclusive", n_wr, 4);
    line(4, 2560);
    chk("R4 row below bottom", n_wr, 0);
    chk("R3 busy during frame", busy, 1);
    sof();
    chk("R3 busy cleared at frame end", busy, 0);
  endtask

  task automatic t_full_width();
    gnt_gap = 1'b1;
    setup(479, 479, 0, 639, 10'h3C3);
    sof();
    line(479, 1000);
    chk("R4 full width count", n_wr, 640);
    chk("R4 full width first", first_a, 1000);
    chk("R4 full width last", last_a, 1639);
    chk("R4 full width consecutive", seq_err, 0);
    chk("R5 hold under withheld grant", hold_err, 0);
    chk("R6 both planes", seen_we, 2'b11);
    gnt_gap = 1'b0;
    sof();
    chk("R3 busy cleared after full width", busy, 0);
  endtask

  task automatic t_empty();
    setup(0, 10, 9, 4, 10'h1FF);
    sof();
    line(5, 0);
    chk("R7 left above right no writes", n_wr, 0);
    chk("R7 busy held", busy, 1);
    sof();
    chk("R7 busy cleared", busy, 0);
    setup(9, 4, 0, 10, 10'h1FF);
    sof();
    line(5, 0);
    chk("R7 top below bottom no writes", n_wr, 0);
    chk("R7 busy held again", busy, 1);
    sof();
    chk("R7 busy cleared again", busy, 0);
  endtask

  task automatic t_noplane();
    setup(0, 10, 0, 3, 10'h0AA);
    sof();
    line(5, 0);
    chk("R6 no planes no writes", n_wr, 0);
    chk("R6 busy held without planes", busy, 1);
    sof();
    chk("R6 busy cleared", busy, 0);
  endtask

  task automatic t_latch();
    setup(0, 10, 3, 4, 10'h2E7);
    sof();
    cpu_write(3'd2, 10'd100);
    cpu_write(3'd4, 10'h1FF);
    line(5, 3200);
    chk("R8 captured left used", first_a, 3203);
    chk("R8 count with captured edges", n_wr, 2);
    chk("R9 word unchanged while busy", seen_data, 8'hE7);
    chk("R9 planes unchanged while busy", seen_we, 2'b10);
    sof();
    chk("R3 busy cleared", busy, 0);
    sof();
    chk("R9 no re-arm from busy write", busy, 0);
    line(5, 3200);
    chk("R9 no writes next frame", n_wr, 0);
  endtask

  initial begin
    clr_mon();
    waiting = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_basic();
    t_full_width();
    t_empty();
    t_noplane();
    t_latch();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule